// File: doc/BRIEF.md
# Watchdog Refresh Unlock Gate

This block stands in front of a watchdog's refresh register and decides whether a refresh write may reach the counter. When locking is on, software must first write a 16-bit unlock word to the unlock target. If the word matches the one that the selected method expects, a refresh window opens. While the window is open, one write of the 32-bit refresh key to the refresh target produces a single-cycle `refresh_pulse`, which the watchdog counter uses as its restart strobe.

There are four ways to form the expected unlock word. The first uses the programmed password as it is. The second rotates the password left by one bit. The third uses a constant. The fourth is a rolling code built from the previously accepted word. The window can be limited to a programmable number of bus cycles. An unlock word that does not match sets a sticky flag. A refresh write that is not allowed also sets a sticky flag. Software clears either flag by writing 1 to it. When locking is off, the refresh key alone is accepted.

Top module: `wdt_refresh_gate`

## Requirements
- R1: After reset, `refresh_pulse`, `unlocked`, `evt_unlock_fail` and `evt_refresh_viol` are all 0, and the rolling history is empty.
- R2: Method 0 (`cfg_method`=0): with locking on, an unlock write (`wr_sel`=0) whose `wr_data[15:0]` equals `cfg_password` opens the window, and `unlocked` is 1 from the next cycle.
- R3: Method 1: the expected word is `cfg_password` rotated left by one bit, {pw[14:0], pw[15]} (0xED09 gives 0xDA13).
- R4: Method 2: the expected word is the constant 0x55AA, whatever `cfg_password` holds.
- R5: Method 3: the expected word is {L[14:0], L[15] ^ pw[0]}. L is the last accepted unlock word of any method, or `cfg_password` if no word has been accepted since reset. Each acceptance replaces L.
- R6: With locking on, an unlock write that does not match sets `evt_unlock_fail` (status bit 1) from the next cycle and leaves the open or closed state of the window unchanged.
- R7: A refresh write (`wr_sel`=1) carrying 0x5A45524F while the window is open gives `refresh_pulse`=1 for exactly the next cycle and closes the window.
- R8: A refresh write made while the window is closed, or carrying any other value, sets `evt_refresh_viol` (status bit 0), gives no pulse and closes the window.
- R9: With `cfg_period_en`=1 the window stays open for max(`cfg_period`,1) cycles after the accepting edge. A refresh sampled in the last of those cycles is still granted. At the next edge the window closes.
- R10: With `cfg_period_en`=0 an open window stays open until the next refresh write.
- R11: With `cfg_lock_en`=0 a refresh write with the key is granted without any unlock. Unlock writes neither open the window nor set `evt_unlock_fail`.
- R12: A status write (`wr_sel`=2) clears `evt_refresh_viol` where `wr_data[0]`=1 and clears `evt_unlock_fail` where `wr_data[1]`=1. Zero bits leave their flag as it is. `wr_sel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Write target: 0 unlock, 1 refresh, 2 status clear, 3 none |
| wr_data | input | 32 | Write data |
| cfg_lock_en | input | 1 | Require an unlock before a refresh |
| cfg_method | input | 2 | Unlock word method 0..3 |
| cfg_password | input | 16 | Programmed unlock password |
| cfg_period_en | input | 1 | Limit the open window in time |
| cfg_period | input | 16 | Window length in bus cycles |
| refresh_pulse | output | 1 | One-cycle counter restart strobe |
| unlocked | output | 1 | Refresh window is open |
| evt_unlock_fail | output | 1 | Sticky flag for a wrong unlock word |
| evt_refresh_viol | output | 1 | Sticky flag for an illegal refresh |

## Verification
The sharpest collision is the expiry of a timed window falling in the same cycle as a refresh write. Both want to close the window, but only the refresh may produce a pulse. The bench opens a four-cycle window and places the key write exactly in the last open cycle, where a pulse and no violation are required. It then repeats the sequence one cycle later, where a violation and no pulse are required. A cycle-by-cycle behavioural model judges every cycle of both runs, alongside the directed checks.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
   typedef enum logic [1:0] {
      SEL_UNLOCK  = 2'd0,
      SEL_REFRESH = 2'd1,
      SEL_STATUS  = 2'd2,
      SEL_NONE    = 2'd3
   } wsel_e;

   typedef enum logic [1:0] {
      METH_DIRECT  = 2'd0,
      METH_ROTATE  = 2'd1,
      METH_FIXED   = 2'd2,
      METH_ROLLING = 2'd3
   } umeth_e;

   // status bit positions, written back by software to clear
   localparam int EVT_VIOL  = 0;
   localparam int EVT_UFAIL = 1;
   localparam int NUM_EVT   = 2;
endpackage

// File: rtl/wrg_expect.sv
module wrg_expect #(
   parameter int              PWD_W      = 16,
   parameter logic [PWD_W-1:0] FIXED_KEY = 16'h55AA,
   parameter bit              ROLLING_EN = 1'b1
) (
   input  logic [1:0]       method,
   input  logic [PWD_W-1:0] password,
   input  logic [PWD_W-1:0] last_word,
   input  logic             have_last,
   output logic [PWD_W-1:0] expected
);
   import wrg_pkg::*;

   logic [PWD_W-1:0] rot_w;
   logic [PWD_W-1:0] roll_w;

   assign rot_w = {password[PWD_W-2:0], password[PWD_W-1]};

   generate
      if (ROLLING_EN) begin : g_roll
         logic [PWD_W-1:0] base_w;
         // history seeds from the password until a word is accepted
         assign base_w = have_last ? last_word : password;
         assign roll_w = {base_w[PWD_W-2:0], base_w[PWD_W-1] ^ password[0]};
      end else begin : g_noroll
         logic unused_w;
         assign unused_w = ^{last_word, have_last};
         assign roll_w   = password;
      end
   endgenerate

   always_comb begin
      case (umeth_e'(method))
         METH_DIRECT: expected = password;
         METH_ROTATE: expected = rot_w;
         METH_FIXED:  expected = FIXED_KEY;
         default:     expected = roll_w;
      endcase
   end
endmodule

// File: rtl/wrg_window.sv
module wrg_window #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                open_req,
   input  logic                close_req,
   input  logic                period_en,
   input  logic [PERIOD_W-1:0] period,
   output logic                open
);
   logic                open_q;
   logic [PERIOD_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         rem_q  <= '0;
      end else if (open_req) begin
         open_q <= 1'b1;
         rem_q  <= (period == '0) ? '0 : period - 1'b1;
      end else if (close_req) begin
         open_q <= 1'b0;
         rem_q  <= '0;
      end else if (open_q && period_en) begin
         if (rem_q == '0) begin
            open_q <= 1'b0;
         end else begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   assign open = open_q;
endmodule

// File: rtl/wrg_events.sv
module wrg_events #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set,
   input  logic [NUM-1:0] clr,
   output logic [NUM-1:0] flags
);
   generate
      for (genvar i = 0; i < NUM; i++) begin : g_flag
         logic f_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               f_q <= 1'b0;
            end else if (set[i]) begin
               f_q <= 1'b1;
            end else if (clr[i]) begin
               f_q <= 1'b0;
            end
         end
         assign flags[i] = f_q;
      end
   endgenerate
endmodule

// File: rtl/wdt_refresh_gate.sv
module wdt_refresh_gate #(
   parameter int               DATA_W       = 32,
   parameter int               PWD_W        = 16,
   parameter int               KEY_W        = 32,
   parameter int               PERIOD_W     = 16,
   parameter logic [KEY_W-1:0] REFRESH_KEY  = 32'h5A45524F,
   parameter logic [PWD_W-1:0] FIXED_UNLOCK = 16'h55AA,
   parameter bit               ROLLING_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                cfg_lock_en,
   input  logic [1:0]          cfg_method,
   input  logic [PWD_W-1:0]    cfg_password,
   input  logic                cfg_period_en,
   input  logic [PERIOD_W-1:0] cfg_period,
   output logic                refresh_pulse,
   output logic                unlocked,
   output logic                evt_unlock_fail,
   output logic                evt_refresh_viol
);
   import wrg_pkg::*;

   generate
      if (PWD_W < 2) begin : g_bad_pwd
         $error("PWD_W must be at least 2");
      end
      if (KEY_W > DATA_W || PWD_W > DATA_W) begin : g_bad_key
         $error("keys must fit in the write data");
      end
      if (DATA_W < NUM_EVT) begin : g_bad_data
         $error("write data too narrow for status bits");
      end
   endgenerate

   logic               unlock_wr, refresh_wr, status_wr;
   logic               word_ok, key_ok, accept, grant;
   logic [PWD_W-1:0]   exp_word;
   logic [PWD_W-1:0]   last_q;
   logic               have_q;
   logic               pulse_q;
   logic               win_open;
   logic [NUM_EVT-1:0] evt_set, evt_clr, evt_q;

   assign unlock_wr  = wr_en && (wsel_e'(wr_sel) == SEL_UNLOCK);
   assign refresh_wr = wr_en && (wsel_e'(wr_sel) == SEL_REFRESH);
   assign status_wr  = wr_en && (wsel_e'(wr_sel) == SEL_STATUS);

   wrg_expect #(
      .PWD_W     (PWD_W),
      .FIXED_KEY (FIXED_UNLOCK),
      .ROLLING_EN(ROLLING_EN)
   ) u_expect (
      .method   (cfg_method),
      .password (cfg_password),
      .last_word(last_q),
      .have_last(have_q),
      .expected (exp_word)
   );

   assign word_ok = (wr_data[PWD_W-1:0] == exp_word);
   assign key_ok  = (wr_data[KEY_W-1:0] == REFRESH_KEY);
   assign accept  = unlock_wr && cfg_lock_en && word_ok;
   assign grant   = refresh_wr && key_ok && (!cfg_lock_en || win_open);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q  <= '0;
         have_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= grant;
         if (accept) begin
            last_q <= wr_data[PWD_W-1:0];
            have_q <= 1'b1;
         end
      end
   end

   wrg_window #(.PERIOD_W(PERIOD_W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_req (accept),
      .close_req(refresh_wr),
      .period_en(cfg_period_en),
      .period   (cfg_period),
      .open     (win_open)
   );

   always_comb begin
      evt_set            = '0;
      evt_set[EVT_VIOL]  = refresh_wr && !grant;
      evt_set[EVT_UFAIL] = unlock_wr && cfg_lock_en && !word_ok;
      evt_clr            = status_wr ? wr_data[NUM_EVT-1:0] : '0;
   end

   wrg_events #(.NUM(NUM_EVT)) u_events (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (evt_set),
      .clr  (evt_clr),
      .flags(evt_q)
   );

   assign refresh_pulse    = pulse_q;
   assign unlocked         = win_open;
   assign evt_refresh_viol = evt_q[EVT_VIOL];
   assign evt_unlock_fail  = evt_q[EVT_UFAIL];
endmodule

// File: rtl/wrg_checker.sv
module wrg_checker #(
   parameter int               DATA_W      = 32,
   parameter int               KEY_W       = 32,
   parameter logic [KEY_W-1:0] REFRESH_KEY = 32'h5A45524F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              cfg_lock_en,
   input logic              cfg_period_en,
   input logic              refresh_pulse,
   input logic              unlocked,
   input logic              evt_unlock_fail,
   input logic              evt_refresh_viol
);
   // R7: a pulse always follows a key write on the refresh target
   a_r7_pulse_has_key: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_pulse |-> $past(wr_en && wr_sel == 2'd1 && wr_data[KEY_W-1:0] == REFRESH_KEY));

   // R7: a granted refresh leaves the window closed
   a_r7_pulse_closes: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_pulse |-> !unlocked);

   // R8: violation flag rises only after a refresh-target write
   a_r8_viol_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_refresh_viol) |-> $past(wr_en && wr_sel == 2'd1));

   // R6: unlock-fail flag rises only after an unlock write with locking on
   a_r6_ufail_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_unlock_fail) |-> $past(wr_en && wr_sel == 2'd0 && cfg_lock_en));

   // R11: the window opens only through an unlock write with locking on
   a_r11_open_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en && wr_sel == 2'd0 && cfg_lock_en));

   // R9, R10: the window closes only by a refresh write or a timed expiry
   a_r9_close_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unlocked) |-> $past((wr_en && wr_sel == 2'd1) || cfg_period_en));

   // R12: flags fall only by a status write with the matching bit
   a_r12_viol_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(evt_refresh_viol) |-> $past(wr_en && wr_sel == 2'd2 && wr_data[0]));
   a_r12_ufail_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(evt_unlock_fail) |-> $past(wr_en && wr_sel == 2'd2 && wr_data[1]));
endmodule

bind wdt_refresh_gate wrg_checker #(
   .DATA_W     (DATA_W),
   .KEY_W      (KEY_W),
   .REFRESH_KEY(REFRESH_KEY)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en           (wr_en),
   .wr_sel          (wr_sel),
   .wr_data         (wr_data),
   .cfg_lock_en     (cfg_lock_en),
   .cfg_period_en   (cfg_period_en),
   .refresh_pulse   (refresh_pulse),
   .unlocked        (unlocked),
   .evt_unlock_fail (evt_unlock_fail),
   .evt_refresh_viol(evt_refresh_viol)
);

// File: tb/wdt_refresh_gate_tb.sv
`timescale 1ns/1ps
module wdt_refresh_gate_tb;
   localparam logic [31:0] KEY = 32'h5A45524F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [31:0] wr_data = '0;
   logic        cfg_lock_en = 1'b1;
   logic [1:0]  cfg_method = 2'd0;
   logic [15:0] cfg_password = 16'hED09;
   logic        cfg_period_en = 1'b0;
   logic [15:0] cfg_period = 16'd4;
   logic        refresh_pulse, unlocked, evt_unlock_fail, evt_refresh_viol;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   wdt_refresh_gate u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cfg_lock_en(cfg_lock_en), .cfg_method(cfg_method), .cfg_password(cfg_password),
      .cfg_period_en(cfg_period_en), .cfg_period(cfg_period),
      .refresh_pulse(refresh_pulse), .unlocked(unlocked),
      .evt_unlock_fail(evt_unlock_fail), .evt_refresh_viol(evt_refresh_viol)
   );

   // ---------------- behavioural reference ----------------
   bit m_open, m_pulse, m_fu, m_fv, m_have;
   int m_rem;
   logic [15:0] m_last;

   function automatic logic [15:0] want_word(logic [1:0] m, logic [15:0] pw,
                                             logic [15:0] last, bit have);
      logic [15:0] b;
      b = have ? last : pw;
      case (m)
         2'd0: return pw;
         2'd1: return {pw[14:0], pw[15]};
         2'd2: return 16'h55AA;
         default: return {b[14:0], b[15] ^ pw[0]};
      endcase
   endfunction

   always @(posedge clk) begin
      bit is_unl, is_ref, ok_word, granted;
      if (!rst_n) begin
         m_open = 0; m_pulse = 0; m_fu = 0; m_fv = 0; m_have = 0; m_rem = 0; m_last = '0;
      end else begin
         is_unl  = wr_en && wr_sel == 2'd0 && cfg_lock_en;
         is_ref  = wr_en && wr_sel == 2'd1;
         ok_word = wr_data[15:0] == want_word(cfg_method, cfg_password, m_last, m_have);
         granted = is_ref && wr_data == KEY && (!cfg_lock_en || m_open);
         m_pulse = granted;
         if (is_ref && !granted) m_fv = 1;
         if (is_unl && !ok_word) m_fu = 1;
         if (wr_en && wr_sel == 2'd2) begin
            if (wr_data[0]) m_fv = 0;
            if (wr_data[1]) m_fu = 0;
         end
         if (is_unl && ok_word) begin
            m_open = 1;
            m_rem  = (cfg_period == 0) ? 0 : int'(cfg_period) - 1;
            m_last = wr_data[15:0];
            m_have = 1;
         end else if (is_ref) begin
            m_open = 0;
         end else if (m_open && cfg_period_en) begin
            if (m_rem == 0) m_open = 0;
            else m_rem = m_rem - 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if ({refresh_pulse, unlocked, evt_unlock_fail, evt_refresh_viol} !==
             {m_pulse, m_open, m_fu, m_fv}) begin
            n_errors++;
            $display("FAIL %s model: pulse/open/ufail/viol act=%b%b%b%b exp=%b%b%b%b", cur_req,
                     refresh_pulse, unlocked, evt_unlock_fail, evt_refresh_viol,
                     m_pulse, m_open, m_fu, m_fv);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
      end
   endtask

   // called at a negedge, returns at the negedge after the sampling edge
   task automatic wr(logic [1:0] sel, logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_checks++; n_errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1", "pulse", refresh_pulse, 1'b0);
      chk("R1", "unlocked", unlocked, 1'b0);
      chk("R1", "ufail", evt_unlock_fail, 1'b0);
      chk("R1", "viol", evt_refresh_viol, 1'b0);

      cur_req = "R2"; cfg_method = 2'd0;
      wr(2'd0, 32'h0000ED09);
      chk("R2", "unlocked after direct word", unlocked, 1'b1);
      cur_req = "R7";
      wr(2'd1, KEY);
      chk("R7", "pulse", refresh_pulse, 1'b1);
      chk("R7", "window closed", unlocked, 1'b0);
      idle(1);
      chk("R7", "pulse one cycle", refresh_pulse, 1'b0);

      cur_req = "R3"; cfg_method = 2'd1;
      wr(2'd0, 32'h0000DA13);
      chk("R3", "unlocked rotate", unlocked, 1'b1);
      wr(2'd1, KEY);
      chk("R3", "pulse", refresh_pulse, 1'b1);

      cur_req = "R4"; cfg_method = 2'd2;
      wr(2'd0, 32'h000055AA);
      chk("R4", "unlocked fixed", unlocked, 1'b1);
      wr(2'd1, KEY);

      cur_req = "R5"; cfg_method = 2'd3;
      wr(2'd0, 32'h0000AB55);
      chk("R5", "rolling first", unlocked, 1'b1);
      wr(2'd1, KEY);
      wr(2'd0, 32'h000056AA);
      chk("R5", "rolling second", unlocked, 1'b1);
      chk("R5", "no fail", evt_unlock_fail, 1'b0);

      cur_req = "R6";
      wr(2'd0, 32'h0000AB55);
      chk("R6", "ufail set", evt_unlock_fail, 1'b1);
      chk("R6", "window kept open", unlocked, 1'b1);
      wr(2'd1, KEY);
      wr(2'd0, 32'h00001111);
      chk("R6", "window kept closed", unlocked, 1'b0);

      cur_req = "R12";
      wr(2'd2, 32'h00000001);
      chk("R12", "bit0 leaves ufail", evt_unlock_fail, 1'b1);
      wr(2'd3, 32'hFFFFFFFF);
      chk("R12", "sel3 no effect", evt_unlock_fail, 1'b1);
      wr(2'd2, 32'h00000002);
      chk("R12", "ufail cleared", evt_unlock_fail, 1'b0);

      cur_req = "R8"; cfg_method = 2'd0;
      wr(2'd1, KEY);
      chk("R8", "closed refresh viol", evt_refresh_viol, 1'b1);
      chk("R8", "no pulse", refresh_pulse, 1'b0);
      wr(2'd2, 32'h00000001);
      chk("R12", "viol cleared", evt_refresh_viol, 1'b0);
      wr(2'd0, 32'h0000ED09);
      wr(2'd1, KEY ^ 32'h1);
      chk("R8", "wrong key viol", evt_refresh_viol, 1'b1);
      chk("R8", "wrong key closes", unlocked, 1'b0);
      chk("R8", "wrong key no pulse", refresh_pulse, 1'b0);
      wr(2'd2, 32'h00000003);

      cur_req = "R9"; cfg_period_en = 1'b1; cfg_period = 16'd4;
      wr(2'd0, 32'h0000ED09);
      idle(3);
      chk("R9", "open in last cycle", unlocked, 1'b1);
      wr(2'd1, KEY);
      chk("R9", "last-cycle refresh granted", refresh_pulse, 1'b1);
      chk("R9", "no viol", evt_refresh_viol, 1'b0);
      wr(2'd0, 32'h0000ED09);
      idle(4);
      chk("R9", "expired", unlocked, 1'b0);
      wr(2'd1, KEY);
      chk("R9", "late refresh viol", evt_refresh_viol, 1'b1);
      chk("R9", "late refresh no pulse", refresh_pulse, 1'b0);
      wr(2'd2, 32'h00000003);
      cfg_period = 16'd0;
      wr(2'd0, 32'h0000ED09);
      chk("R9", "period 0 open one cycle", unlocked, 1'b1);
      idle(1);
      chk("R9", "period 0 closed", unlocked, 1'b0);

      cur_req = "R10"; cfg_period_en = 1'b0;
      wr(2'd0, 32'h0000ED09);
      idle(40);
      chk("R10", "still open", unlocked, 1'b1);
      wr(2'd1, KEY);
      chk("R10", "pulse", refresh_pulse, 1'b1);

      cur_req = "R11"; cfg_lock_en = 1'b0;
      wr(2'd0, 32'h00001234);
      chk("R11", "unlock ignored open", unlocked, 1'b0);
      chk("R11", "unlock ignored flag", evt_unlock_fail, 1'b0);
      wr(2'd1, KEY);
      chk("R11", "key alone pulse", refresh_pulse, 1'b1);
      chk("R11", "no viol", evt_refresh_viol, 1'b0);
      idle(2);
      finish_run();
   end
endmodule